// File: doc/BRIEF.md
# APS K1/K2 Byte Source Selector

This block sits in the transmit multiplex section overhead path and decides which byte goes out on the line in each byte slot. In the K1 slot it sends either the byte from the serial overhead input or a processor-written K1 value. In the K2 slot it sends either the serial overhead byte or a byte built in hardware. The hardware byte either takes all its bits from a processor-written K2 value, or keeps the upper bits of that value and replaces the three lowest bits with the MS-RDI code whenever the receiver reports a remote defect. In the AU pointer and payload slots a forced alarm indication can replace the incoming byte with all ones. All other slots carry the incoming byte unchanged.

Every configuration input, both register values and the receiver RDI level are copied into a shadow set on the frame boundary strobe. The copy is taken in the frame-boundary cycle. A frame therefore never carries bytes that reflect two different register states. A small state machine follows the operating mode. Its states are ST_HUNT (no frame boundary seen since reset; every byte passes through), ST_INSERT (terminal or add/drop operation; overhead is inserted) and ST_REGEN (regenerator operation; every received byte, including K1 and K2, passes through). Transitions happen only on the frame boundary strobe. The transition to ST_REGEN occurs when the regenerator mode input is high at that strobe. The transition to ST_INSERT occurs when that input is low. With no strobe, the state is held.

The slot strobes are expected to be mutually exclusive. If more than one is high, K1 wins over K2, and K2 wins over AU. The output is registered and appears one clock after the inputs that produced it.

Top module: `aps_kbyte_sel`

## Requirements
- R1: After reset `dout` is 0x00 and the block is in ST_HUNT. Until the first `frame_sync`, `dout` equals `din`, whatever the slot strobes, configuration or register inputs are.
- R2: `dout` is registered. The value that results from the inputs in one cycle appears in the following cycle. Bytes outside the K1, K2 and AU slots pass `din` unchanged in every state.
- R3: In ST_INSERT, a K1 slot outputs `reg_k1` if the latched `k1_from_reg` is 1, and `ser_oh` if it is 0.
- R4: In ST_INSERT, a K2 slot outputs `ser_oh` when the latched `k2_internal` is 0, and the hardware-built K2 byte when it is 1.
- R5: Hardware K2 with the latched `rdi_from_reg` = 0 takes bits [7:3] from `reg_k2`. Bits [2:0] are 3'b110 when the latched `rx_rdi` is 1, and `reg_k2[2:0]` when it is 0.
- R6: Hardware K2 with the latched `rdi_from_reg` = 1 equals `reg_k2` in all eight bits, and `rx_rdi` has no effect on it.
- R7: In ST_INSERT with the latched `ais_force` = 1, an AU slot outputs 0xFF. K1, K2 and all other slots are unaffected by `ais_force`.
- R8: In ST_REGEN every slot outputs `din`. Register values, source selects and `ais_force` have no effect.
- R9: `reg_k1`, `reg_k2`, `rx_rdi`, `regen_en` and all select bits take effect only through the copy made in a `frame_sync` cycle. A change that occurs between strobes does not alter the output before the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame boundary strobe; copies configuration and picks the next state |
| slot_k1 | input | 1 | Current byte is the K1 slot |
| slot_k2 | input | 1 | Current byte is the K2 slot |
| slot_au | input | 1 | Current byte is an AU pointer or payload byte |
| regen_en | input | 1 | Regenerator mode request (1) versus terminal/add-drop (0) |
| din | input | 8 | Incoming frame byte for the current slot |
| ser_oh | input | 8 | Serial overhead byte for the current slot |
| rx_rdi | input | 1 | Receiver remote defect indication |
| k1_from_reg | input | 1 | K1 source: 1 register, 0 serial overhead |
| k2_internal | input | 1 | K2 source: 1 hardware-built, 0 serial overhead |
| rdi_from_reg | input | 1 | Hardware K2 RDI source: 1 register, 0 receiver |
| ais_force | input | 1 | Force all ones into AU slots |
| reg_k1 | input | 8 | Processor K1 value |
| reg_k2 | input | 8 | Processor K2 value |
| dout | output | 8 | Byte to transmit, one cycle after its inputs |

## Verification
Directed sequences cover each source choice in turn. The K2 register value uses zero low bits, so the RDI merge is visible against a whole-register copy. The receiver RDI is toggled under both RDI sources, which separates the merged byte from the register copy. Register and select values are changed between strobes to show that the shadow copy, and not the live inputs, drives the output. A seeded random run then mixes states, slots and configuration at random frame lengths. It compares every byte with a bench model, which catches wrong priorities, missed state transitions and stray AIS fill outside the AU slots.

// File: rtl/aps_kbyte_pkg.sv
package aps_kbyte_pkg;

    localparam int BYTE_W = 8;
    localparam int RDI_W  = 3;
    localparam logic [RDI_W-1:0] RDI_CODE = 3'b110;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_INSERT = 2'd1,
        ST_REGEN  = 2'd2
    } aps_st_e;

    typedef struct packed {
        logic              regen;
        logic              k1_from_reg;
        logic              k2_internal;
        logic              rdi_from_reg;
        logic              ais_force;
        logic              rx_rdi;
        logic [BYTE_W-1:0] k1;
        logic [BYTE_W-1:0] k2;
    } aps_shadow_t;

endpackage

// File: rtl/aps_cfg_shadow.sv
module aps_cfg_shadow
    import aps_kbyte_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_sync,
    input  aps_shadow_t live,
    output aps_shadow_t held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (frame_sync) begin
            held <= live;
        end
    end

endmodule

// File: rtl/aps_k2_merge.sv
module aps_k2_merge
    import aps_kbyte_pkg::*;
#(
    parameter int                W_BYTE = BYTE_W,
    parameter int                W_RDI  = RDI_W,
    parameter logic [W_RDI-1:0]  CODE   = RDI_CODE
) (
    input  logic              rdi_from_reg,
    input  logic              rx_rdi,
    input  logic [W_BYTE-1:0] k2_reg,
    output logic [W_BYTE-1:0] k2_out
);

    logic [W_RDI-1:0] low_bits;

    always_comb begin
        low_bits = rx_rdi ? CODE : k2_reg[W_RDI-1:0];
        if (rdi_from_reg) begin
            k2_out = k2_reg;
        end else begin
            k2_out = {k2_reg[W_BYTE-1:W_RDI], low_bits};
        end
    end

endmodule

// File: rtl/aps_mode_fsm.sv
module aps_mode_fsm
    import aps_kbyte_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    frame_sync,
    input  logic    regen_req,
    output aps_st_e st,
    output logic    insert_on
);

    aps_st_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_HUNT;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx     = st;
        insert_on = 1'b0;
        unique case (st)
            ST_HUNT: begin
                if (frame_sync) st_nx = regen_req ? ST_REGEN : ST_INSERT;
            end
            ST_INSERT: begin
                insert_on = 1'b1;
                if (frame_sync && regen_req) st_nx = ST_REGEN;
            end
            ST_REGEN: begin
                if (frame_sync && !regen_req) st_nx = ST_INSERT;
            end
            default: begin
                st_nx = ST_HUNT;
            end
        endcase
    end

endmodule

// File: rtl/aps_kbyte_sel.sv
module aps_kbyte_sel
    import aps_kbyte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              slot_k1,
    input  logic              slot_k2,
    input  logic              slot_au,
    input  logic              regen_en,
    input  logic [BYTE_W-1:0] din,
    input  logic [BYTE_W-1:0] ser_oh,
    input  logic              rx_rdi,
    input  logic              k1_from_reg,
    input  logic              k2_internal,
    input  logic              rdi_from_reg,
    input  logic              ais_force,
    input  logic [BYTE_W-1:0] reg_k1,
    input  logic [BYTE_W-1:0] reg_k2,
    output logic [BYTE_W-1:0] dout
);

    aps_shadow_t       live;
    aps_shadow_t       held;
    aps_st_e           st_q;
    logic              insert_on;
    logic [BYTE_W-1:0] k2_hw;
    logic [BYTE_W-1:0] byte_sel;

    always_comb begin
        live.regen        = regen_en;
        live.k1_from_reg  = k1_from_reg;
        live.k2_internal  = k2_internal;
        live.rdi_from_reg = rdi_from_reg;
        live.ais_force    = ais_force;
        live.rx_rdi       = rx_rdi;
        live.k1           = reg_k1;
        live.k2           = reg_k2;
    end

    aps_cfg_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .live       (live),
        .held       (held)
    );

    aps_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .regen_req  (regen_en),
        .st         (st_q),
        .insert_on  (insert_on)
    );

    aps_k2_merge u_merge (
        .rdi_from_reg (held.rdi_from_reg),
        .rx_rdi       (held.rx_rdi),
        .k2_reg       (held.k2),
        .k2_out       (k2_hw)
    );

    always_comb begin
        byte_sel = din;
        if (insert_on) begin
            if (slot_k1) begin
                byte_sel = held.k1_from_reg ? held.k1 : ser_oh;
            end else if (slot_k2) begin
                byte_sel = held.k2_internal ? k2_hw : ser_oh;
            end else if (slot_au && held.ais_force) begin
                byte_sel = '1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else begin
            dout <= byte_sel;
        end
    end

endmodule

// File: rtl/aps_kbyte_chk.sv
module aps_kbyte_chk
    import aps_kbyte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              slot_k1,
    input  logic              slot_k2,
    input  logic              slot_au,
    input  logic [BYTE_W-1:0] din,
    input  logic [BYTE_W-1:0] ser_oh,
    input  logic [BYTE_W-1:0] dout,
    input  aps_st_e           st,
    input  aps_shadow_t       held
);

    // R1
    hunt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st) == ST_HUNT) |-> dout == $past(din));

    // R8
    regen_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st) == ST_REGEN) |-> dout == $past(din));

    // R3
    k1_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st) == ST_INSERT && $past(slot_k1)
         && !$past(held.k1_from_reg)) |-> dout == $past(ser_oh));

    // R5
    rdi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st) == ST_INSERT && $past(slot_k2) && !$past(slot_k1)
         && $past(held.k2_internal) && !$past(held.rdi_from_reg) && $past(held.rx_rdi))
        |-> dout[RDI_W-1:0] == RDI_CODE);

    // R7
    ais_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st) == ST_INSERT && $past(slot_au) && !$past(slot_k1)
         && !$past(slot_k2) && $past(held.ais_force)) |-> dout == '1);

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !frame_sync) |=> $stable(held));

    // R9
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !frame_sync) |=> $stable(st));

endmodule

bind aps_kbyte_sel aps_kbyte_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .slot_k1    (slot_k1),
    .slot_k2    (slot_k2),
    .slot_au    (slot_au),
    .din        (din),
    .ser_oh     (ser_oh),
    .dout       (dout),
    .st         (st_q),
    .held       (held)
);

// File: tb/sim_aps_kbyte_sel.sv
module sim_aps_kbyte_sel;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, frame_sync, slot_k1, slot_k2, slot_au, regen_en;
    logic [7:0] din, ser_oh, reg_k1, reg_k2, dout;
    logic       rx_rdi, k1_from_reg, k2_internal, rdi_from_reg, ais_force;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model: 0 hunt, 1 insert, 2 regen
    int         m_st;
    logic       m_k1r, m_k2i, m_rdir, m_ais, m_rdi;
    logic [7:0] m_k1, m_k2;

    aps_kbyte_sel u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .slot_k1(slot_k1), .slot_k2(slot_k2), .slot_au(slot_au),
        .regen_en(regen_en), .din(din), .ser_oh(ser_oh), .rx_rdi(rx_rdi),
        .k1_from_reg(k1_from_reg), .k2_internal(k2_internal),
        .rdi_from_reg(rdi_from_reg), .ais_force(ais_force),
        .reg_k1(reg_k1), .reg_k2(reg_k2), .dout(dout)
    );

    function automatic logic [7:0] model_k2();
        if (m_rdir) return m_k2;
        return {m_k2[7:3], (m_rdi ? 3'b110 : m_k2[2:0])};
    endfunction

    function automatic logic [7:0] model_byte();
        if (m_st != 1) return din;
        if (slot_k1) return m_k1r ? m_k1 : ser_oh;
        if (slot_k2) return m_k2i ? model_k2() : ser_oh;
        if (slot_au && m_ais) return 8'hFF;
        return din;
    endfunction

    function automatic string auto_tag();
        if (m_st == 0) return "R1";
        if (m_st == 2) return "R8";
        if (slot_k1) return "R3";
        if (slot_k2) return m_k2i ? (m_rdir ? "R6" : "R5") : "R4";
        if (slot_au) return "R7";
        return "R2";
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(string req);
        logic [7:0] e;
        e = model_byte();
        @(posedge clk);
        #1;
        if (frame_sync) begin
            m_st   = regen_en ? 2 : 1;
            m_k1r  = k1_from_reg;
            m_k2i  = k2_internal;
            m_rdir = rdi_from_reg;
            m_ais  = ais_force;
            m_rdi  = rx_rdi;
            m_k1   = reg_k1;
            m_k2   = reg_k2;
        end
        @(negedge clk);
        check(req, dout, e);
    endtask

    task automatic slots(logic a, logic b, logic c);
        slot_k1 = a; slot_k2 = b; slot_au = c;
    endtask

    task automatic frame(string req);
        slots(0, 0, 0);
        frame_sync = 1'b1;
        cyc(req);
        frame_sync = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A95));
        m_st = 0; m_k1r = 0; m_k2i = 0; m_rdir = 0; m_ais = 0; m_rdi = 0;
        m_k1 = 0; m_k2 = 0;
        rst_n = 1'b0; frame_sync = 0; regen_en = 0; slots(0, 0, 0);
        din = 8'h5A; ser_oh = 8'h11; rx_rdi = 1; k1_from_reg = 1;
        k2_internal = 1; rdi_from_reg = 0; ais_force = 1;
        reg_k1 = 8'hA5; reg_k2 = 8'hF8;
        repeat (2) @(negedge clk);
        check("R1", dout, 8'h00);
        rst_n = 1'b1;

        // R1: hunt passes everything even with strobes and config active
        din = 8'h3C; slots(1, 0, 0); cyc("R1");
        din = 8'h4D; slots(0, 0, 1); cyc("R1");

        // enter insert with register K1, hardware K2, receiver RDI, AIS on
        frame("R9");
        din = 8'h21; slots(1, 0, 0); cyc("R3");
        k1_from_reg = 0; reg_k1 = 8'h00; ser_oh = 8'h77;
        cyc("R9"); // still old register value
        slots(0, 1, 0); cyc("R5"); // F8 merged with RDI -> FE
        rx_rdi = 0; cyc("R9");     // latched RDI still 1
        slots(0, 0, 1); din = 8'h12; cyc("R7");
        slots(0, 0, 0); din = 8'h34; cyc("R7");

        // new frame: serial K1, RDI now clear
        frame("R9");
        slots(1, 0, 0); ser_oh = 8'h66; cyc("R3");
        slots(0, 1, 0); cyc("R5"); // F8
        rdi_from_reg = 1; reg_k2 = 8'h3D; rx_rdi = 1; ais_force = 0;
        frame("R9");
        slots(0, 1, 0); cyc("R6"); // 3D, RDI ignored
        slots(0, 0, 1); din = 8'h9E; cyc("R7");
        k2_internal = 0;
        frame("R9");
        slots(0, 1, 0); ser_oh = 8'hC3; cyc("R4");

        // regenerator: all pass
        regen_en = 1; ais_force = 1; k1_from_reg = 1;
        frame("R8");
        slots(1, 0, 0); din = 8'h44; cyc("R8");
        slots(0, 0, 1); din = 8'h55; cyc("R8");
        regen_en = 0;
        slots(0, 1, 0); din = 8'h56; cyc("R9"); // still regen
        frame("R9");
        slots(0, 0, 1); din = 8'h57; cyc("R7");

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            int s;
            frame_sync   = ($urandom % 12) == 0;
            s            = $urandom % 4;
            if (frame_sync) s = 0;
            slots(s == 1, s == 2, s == 3);
            regen_en     = ($urandom % 5) == 0;
            din          = 8'($urandom);
            ser_oh       = 8'($urandom);
            rx_rdi       = 1'($urandom);
            k1_from_reg  = 1'($urandom);
            k2_internal  = 1'($urandom);
            rdi_from_reg = 1'($urandom);
            ais_force    = 1'($urandom);
            reg_k1       = 8'($urandom);
            reg_k2       = 8'($urandom);
            cyc(auto_tag());
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule